// File: doc/BRIEF.md
# Supply Supervisor with Pushbutton Reset Sequencer

This block watches a set of supply-good flags and one active-low pushbutton, and from them produces a hard system reset and a separate soft reset. The hard reset is held while any supply is reported bad. It then stays held for a fixed extension period after every supply is good again. A single button gives one of two outcomes, depending on how long it is held. A short press produces a brief soft-reset pulse once the button is let go. A press held past the long threshold forces the hard reset for as long as the button stays down, and then for the same extension period after release.

Every duration is a parameter in microseconds and is turned into a cycle count from the clock-frequency parameter: EXT_CYC (default 200 ms), LONG_CYC (2 s), PULSE_CYC (100 us) and DEB_CYC (10 ms). Each count is rounded up and is never less than one cycle. The supply flags are already digital. Each flag and the button pass through two synchronizing flops. The button then passes through a debounce filter before any press timing starts.

Top module: `supply_reset_seq`

## Requirements
- R1: A supply_ok bit at 0 means that supply is bad. Such a bit drives hard_rst_n low on the third rising edge after the input change, and hard_rst_n stays high through the first two of those edges.
- R2: Once every supply_ok bit is 1 and no long press is active, hard_rst_n stays low through the (EXT_CYC+1)th rising edge after the change and goes high on the (EXT_CYC+2)th.
- R3: If any supply goes bad during the extension, the extension is cancelled. The full EXT_CYC count starts again once all supplies are good.
- R4: While arst_n is low, hard_rst_n is 0 and soft_rst_n is 1. After reset release with all supplies good, hard_rst_n goes high on the (EXT_CYC+2)th rising edge.
- R5: btn_n (0 = pressed) only takes effect after its synchronized level has differed from the filtered level for DEB_CYC consecutive cycles. Shorter low glitches, and shorter high bounces during a press, have no effect on either reset.
- R6: A press released before LONG_CYC filtered cycles drives soft_rst_n low for exactly PULSE_CYC cycles, starting after the release has passed the debounce filter.
- R7: A press held for LONG_CYC filtered cycles drives hard_rst_n low while the button remains down. A press well short of that leaves hard_rst_n high.
- R8: The release of a long press produces no soft pulse. hard_rst_n stays low through the (DEB_CYC+EXT_CYC+2)th rising edge after release and goes high on the next one.
- R9: A short-press release is ignored (no soft pulse) if the hard reset was already asserted just before the edge that accepts the filtered release.
- R10: hard_rst is at all times the exact complement of hard_rst_n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous reset, active low |
| supply_ok | input | N_SUPPLY | Per-supply good flag, 1 = good |
| btn_n | input | 1 | Pushbutton, active low, asynchronous |
| hard_rst_n | output | 1 | Hard reset, active low |
| hard_rst | output | 1 | Hard reset, active high (complement) |
| soft_rst_n | output | 1 | Soft reset pulse, active low |

## Verification
A filtered short-press release and a supply failure can land on the same clock edge. The release logic then has to decide whether the hard reset counts as already active. The bench times a supply drop after the button release so that the hard reset rises either exactly one edge before the release is accepted or exactly on that edge. In the first case the scoreboard expects no soft pulse. In the second it expects a full PULSE_CYC pulse that overlaps the hard reset.

// File: rtl/srs_pkg.sv
package srs_pkg;

    typedef enum logic [1:0] {
        PB_UP    = 2'd0,
        PB_SHORT = 2'd1,
        PB_LONG  = 2'd2
    } pb_state_e;

    function automatic int unsigned us_to_cycles(input longint unsigned hz,
                                                 input longint unsigned us);
        longint unsigned c;
        c = (hz * us + 64'd999999) / 64'd1000000;
        if (c == 0) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
    parameter int   W       = 1,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stab;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.meta = din;
        sync_d.stab = sync_q.meta;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            sync_q.meta <= {W{RST_VAL}};
            sync_q.stab <= {W{RST_VAL}};
        end else begin
            sync_q <= sync_d;
        end
    end

    assign dout = sync_q.stab;
endmodule

// File: rtl/srs_debounce.sv
module srs_debounce #(
    parameter int   HOLD_CYC = 4,
    parameter logic RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic arst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } deb_t;

    deb_t deb_d, deb_q;

    always_comb begin
        deb_d = deb_q;
        if (raw != deb_q.lvl) begin
            if (deb_q.cnt == CW'(HOLD_CYC - 1)) begin
                deb_d.lvl = raw;
                deb_d.cnt = '0;
            end else begin
                deb_d.cnt = deb_q.cnt + 1'b1;
            end
        end else begin
            deb_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            deb_q.lvl <= RST_VAL;
            deb_q.cnt <= '0;
        end else begin
            deb_q <= deb_d;
        end
    end

    assign clean = deb_q.lvl;
endmodule

// File: rtl/srs_press_ctl.sv
module srs_press_ctl
    import srs_pkg::*;
#(
    parameter int LONG_CYC  = 16,
    parameter int PULSE_CYC = 4
) (
    input  logic clk,
    input  logic arst_n,
    input  logic btn_db_n,
    input  logic hard_busy,
    output logic long_hold,
    output logic soft_pulse
);
    localparam int LW = (LONG_CYC < 2) ? 1 : $clog2(LONG_CYC);
    localparam int PW = (PULSE_CYC < 2) ? 1 : $clog2(PULSE_CYC);

    typedef struct packed {
        pb_state_e     st;
        logic [LW-1:0] held;
        logic          pulse;
        logic [PW-1:0] width;
    } press_t;

    press_t pr_d, pr_q;
    logic   pressed;

    assign pressed = ~btn_db_n;

    always_comb begin
        pr_d = pr_q;

        // soft pulse length
        if (pr_q.pulse) begin
            if (pr_q.width == PW'(PULSE_CYC - 1)) begin
                pr_d.pulse = 1'b0;
                pr_d.width = '0;
            end else begin
                pr_d.width = pr_q.width + 1'b1;
            end
        end

        // press duration classification
        unique case (pr_q.st)
            PB_UP: begin
                if (pressed) begin
                    pr_d.st   = PB_SHORT;
                    pr_d.held = '0;
                end
            end
            PB_SHORT: begin
                if (!pressed) begin
                    pr_d.st   = PB_UP;
                    pr_d.held = '0;
                    if (!hard_busy) begin
                        pr_d.pulse = 1'b1;
                        pr_d.width = '0;
                    end
                end else if (pr_q.held == LW'(LONG_CYC - 1)) begin
                    pr_d.st = PB_LONG;
                end else begin
                    pr_d.held = pr_q.held + 1'b1;
                end
            end
            PB_LONG: begin
                if (!pressed) begin
                    pr_d.st   = PB_UP;
                    pr_d.held = '0;
                end
            end
            default: begin
                pr_d.st   = PB_UP;
                pr_d.held = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            pr_q.st    <= PB_UP;
            pr_q.held  <= '0;
            pr_q.pulse <= 1'b0;
            pr_q.width <= '0;
        end else begin
            pr_q <= pr_d;
        end
    end

    assign long_hold  = (pr_q.st == PB_LONG);
    assign soft_pulse = pr_q.pulse;
endmodule

// File: rtl/srs_hold_timer.sv
module srs_hold_timer #(
    parameter int EXT_CYC = 16
) (
    input  logic clk,
    input  logic arst_n,
    input  logic cause,
    output logic active
);
    localparam int EW = (EXT_CYC < 2) ? 1 : $clog2(EXT_CYC);

    typedef struct packed {
        logic          act;
        logic [EW-1:0] cnt;
    } hold_t;

    hold_t hd_d, hd_q;

    always_comb begin
        hd_d = hd_q;
        if (cause) begin
            hd_d.act = 1'b1;
            hd_d.cnt = '0;
        end else if (hd_q.act) begin
            if (hd_q.cnt == EW'(EXT_CYC - 1)) begin
                hd_d.act = 1'b0;
                hd_d.cnt = '0;
            end else begin
                hd_d.cnt = hd_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            hd_q.act <= 1'b1;
            hd_q.cnt <= '0;
        end else begin
            hd_q <= hd_d;
        end
    end

    assign active = hd_q.act;
endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq
    import srs_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 125_000_000,
    parameter int unsigned N_SUPPLY = 3,
    parameter int unsigned EXT_US   = 200_000,
    parameter int unsigned LONG_US  = 2_000_000,
    parameter int unsigned PULSE_US = 100,
    parameter int unsigned DEB_US   = 10_000
) (
    input  logic                clk,
    input  logic                arst_n,
    input  logic [N_SUPPLY-1:0] supply_ok,
    input  logic                btn_n,
    output logic                hard_rst_n,
    output logic                hard_rst,
    output logic                soft_rst_n
);
    localparam int EXT_CYC   = int'(us_to_cycles(longint'(CLK_HZ), longint'(EXT_US)));
    localparam int LONG_CYC  = int'(us_to_cycles(longint'(CLK_HZ), longint'(LONG_US)));
    localparam int PULSE_CYC = int'(us_to_cycles(longint'(CLK_HZ), longint'(PULSE_US)));
    localparam int DEB_CYC   = int'(us_to_cycles(longint'(CLK_HZ), longint'(DEB_US)));

    logic [N_SUPPLY-1:0] sup_sync;
    logic                btn_sync;
    logic                btn_db_n;
    logic                sup_bad;
    logic                long_hold;
    logic                hard_active;
    logic                soft_pulse;

    srs_sync #(.W(N_SUPPLY), .RST_VAL(1'b0)) u_sup_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .din    (supply_ok),
        .dout   (sup_sync)
    );

    srs_sync #(.W(1), .RST_VAL(1'b1)) u_btn_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .din    (btn_n),
        .dout   (btn_sync)
    );

    srs_debounce #(.HOLD_CYC(DEB_CYC), .RST_VAL(1'b1)) u_btn_deb (
        .clk    (clk),
        .arst_n (arst_n),
        .raw    (btn_sync),
        .clean  (btn_db_n)
    );

    srs_press_ctl #(.LONG_CYC(LONG_CYC), .PULSE_CYC(PULSE_CYC)) u_press (
        .clk        (clk),
        .arst_n     (arst_n),
        .btn_db_n   (btn_db_n),
        .hard_busy  (hard_active),
        .long_hold  (long_hold),
        .soft_pulse (soft_pulse)
    );

    assign sup_bad = ~(&sup_sync);

    srs_hold_timer #(.EXT_CYC(EXT_CYC)) u_hold (
        .clk    (clk),
        .arst_n (arst_n),
        .cause  (sup_bad | long_hold),
        .active (hard_active)
    );

    assign hard_rst_n = ~hard_active;
    assign hard_rst   = hard_active;
    assign soft_rst_n = ~soft_pulse;
endmodule

// File: rtl/supply_reset_seq_chk.sv
module supply_reset_seq_chk #(
    parameter int EXT_CYC   = 16,
    parameter int PULSE_CYC = 4
) (
    input logic clk,
    input logic arst_n,
    input logic sup_bad,
    input logic long_hold,
    input logic hard_rst_n,
    input logic hard_rst,
    input logic soft_rst_n
);
    logic [31:0] quiet_q;
    logic [31:0] low_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            quiet_q <= '0;
            low_q   <= '0;
        end else begin
            if (sup_bad || long_hold) quiet_q <= '0;
            else if (quiet_q < 32'(EXT_CYC)) quiet_q <= quiet_q + 1;
            if (!soft_rst_n) low_q <= low_q + 1;
            else             low_q <= '0;
        end
    end

    // R1
    sup_bad_chk: assert property (@(posedge clk) disable iff (!arst_n)
        sup_bad |=> !hard_rst_n);

    // R2 R3
    ext_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (quiet_q < 32'(EXT_CYC)) |-> !hard_rst_n);

    // R2
    ext_release_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (quiet_q >= 32'(EXT_CYC)) |-> hard_rst_n);

    // R6
    pulse_width_chk: assert property (@(posedge clk) disable iff (!arst_n)
        !soft_rst_n |-> (low_q < 32'(PULSE_CYC)));

    // R6
    pulse_end_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(soft_rst_n) |-> (low_q == 32'(PULSE_CYC)));

    // R7
    long_force_chk: assert property (@(posedge clk) disable iff (!arst_n)
        long_hold |=> !hard_rst_n);

    // R8
    long_no_soft_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(long_hold) |-> soft_rst_n);

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(soft_rst_n) |-> $past(hard_rst_n));

    // R10
    polarity_chk: assert property (@(posedge clk) disable iff (!arst_n)
        hard_rst == !hard_rst_n);
endmodule

bind supply_reset_seq supply_reset_seq_chk #(
    .EXT_CYC   (EXT_CYC),
    .PULSE_CYC (PULSE_CYC)
) u_chk (
    .clk        (clk),
    .arst_n     (arst_n),
    .sup_bad    (sup_bad),
    .long_hold  (long_hold),
    .hard_rst_n (hard_rst_n),
    .hard_rst   (hard_rst),
    .soft_rst_n (soft_rst_n)
);

// File: tb/supply_reset_seq_bench.sv
`timescale 1ns/1ps
module supply_reset_seq_bench;
    localparam int EXT   = 300;
    localparam int LONG  = 2000;
    localparam int PULSE = 8;
    localparam int DEB   = 40;

    logic       clk = 1'b0;
    logic       arst_n = 1'b0;
    logic [2:0] supply_ok = 3'b111;
    logic       btn_n = 1'b1;
    logic       hard_rst_n, hard_rst, soft_rst_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    string tag_q[$];
    int    len_q[$];
    int    width = 0;

    always #4 clk = ~clk;

    supply_reset_seq #(
        .CLK_HZ(1_000_000), .N_SUPPLY(3), .EXT_US(EXT),
        .LONG_US(LONG), .PULSE_US(PULSE), .DEB_US(DEB)
    ) u_supply_reset_seq (
        .clk(clk), .arst_n(arst_n), .supply_ok(supply_ok), .btn_n(btn_n),
        .hard_rst_n(hard_rst_n), .hard_rst(hard_rst), .soft_rst_n(soft_rst_n)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_pulse(input string req);
        tag_q.push_back(req);
        len_q.push_back(PULSE);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // scoreboard monitor: each soft pulse is matched against the queue
    always @(negedge clk) begin
        if (arst_n) begin
            if (!soft_rst_n) width++;
            else if (width != 0) begin
                if (tag_q.size() == 0) check("R9 unexpected soft pulse", width, 0);
                else begin
                    string t;
                    int    l;
                    t = tag_q.pop_front();
                    l = len_q.pop_front();
                    check(t, width, l);
                end
                width = 0;
            end
        end
    end

    initial begin
        #(8 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        @(negedge clk);
        edges(3);
        // R4 reset state, R10 polarity
        check("R4 hard_rst_n in reset", hard_rst_n, 0);
        check("R4 soft_rst_n in reset", soft_rst_n, 1);
        check("R10 hard_rst in reset", hard_rst, 1);
        arst_n = 1'b1;
        edges(EXT + 1);
        check("R4 still held at power-up", hard_rst_n, 0);
        edges(1);
        check("R4 released after extension", hard_rst_n, 1);
        check("R10 complement", hard_rst, 0);

        // R1 supply failure
        supply_ok = 3'b101;
        edges(2);
        check("R1 not yet asserted", hard_rst_n, 1);
        edges(1);
        check("R1 asserted", hard_rst_n, 0);
        check("R10 complement under fault", hard_rst, 1);
        edges(20);
        // R2 extension
        supply_ok = 3'b111;
        edges(EXT + 1);
        check("R2 held through extension", hard_rst_n, 0);
        edges(1);
        check("R2 released", hard_rst_n, 1);

        // R3 restart on dip during extension
        supply_ok = 3'b110;
        edges(10);
        supply_ok = 3'b111;
        edges(100);
        supply_ok = 3'b011;
        edges(5);
        supply_ok = 3'b111;
        edges(EXT + 1);
        check("R3 extension restarted", hard_rst_n, 0);
        edges(1);
        check("R3 released after full count", hard_rst_n, 1);

        // R6 short press
        expect_pulse("R6 short press pulse");
        btn_n = 1'b0;
        edges(500);
        btn_n = 1'b1;
        edges(DEB + PULSE + 30);
        check("R6 hard reset untouched", hard_rst_n, 1);

        // R5 glitch shorter than debounce
        btn_n = 1'b0;
        edges(20);
        btn_n = 1'b1;
        edges(DEB + 60);
        check("R5 glitch no soft pulse", soft_rst_n, 1);
        // R5 bounce during a press yields one pulse
        expect_pulse("R5 bounced press single pulse");
        btn_n = 1'b0;
        edges(200);
        btn_n = 1'b1;
        edges(20);
        btn_n = 1'b0;
        edges(200);
        btn_n = 1'b1;
        edges(DEB + PULSE + 30);

        // R7 / R8 long press
        btn_n = 1'b0;
        edges(1000);
        check("R7 below long threshold", hard_rst_n, 1);
        edges(LONG + DEB + 100 - 1000);
        check("R7 forced while held", hard_rst_n, 0);
        btn_n = 1'b1;
        edges(DEB + EXT + 2);
        check("R8 held after long release", hard_rst_n, 0);
        edges(1);
        check("R8 released after extension", hard_rst_n, 1);
        check("R8 no soft pulse", soft_rst_n, 1);

        // R9 release during hard reset
        supply_ok = 3'b011;
        edges(5);
        btn_n = 1'b0;
        edges(300);
        btn_n = 1'b1;
        edges(DEB + 50);
        check("R9 hard still active", hard_rst_n, 0);
        supply_ok = 3'b111;
        edges(EXT + 10);

        // R9 hard reset rises one edge before release acceptance: ignored
        btn_n = 1'b0;
        edges(300);
        btn_n = 1'b1;
        edges(DEB - 1);
        supply_ok = 3'b110;
        edges(100);
        check("R9 coincident-early no pulse", soft_rst_n, 1);
        supply_ok = 3'b111;
        edges(EXT + 10);

        // R9 hard reset rises on the acceptance edge: pulse still issued
        expect_pulse("R9 coincident-late pulse");
        btn_n = 1'b0;
        edges(300);
        btn_n = 1'b1;
        edges(DEB);
        supply_ok = 3'b110;
        edges(100);
        supply_ok = 3'b111;
        edges(EXT + 10);
        check("R2 final release", hard_rst_n, 1);

        edges(20);
        check("R6 all expected pulses seen", tag_q.size(), 0);
        finish_run();
    end
endmodule